// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block picks one tap from a binary divider that counts a 32768 Hz base tick. On every edge of the chosen tap it sets a periodic flag. A 4-bit rate code in the low bits of control register A selects the tap. If the enable bit in control register B is set, the flag drives an interrupt line. The line stays high until software reads status register C, and that read clears the flag.

The rate code is not monotonic. Code 0 turns the periodic source off. Codes 3 to 15 run from 8192 Hz down to 2 Hz, and each step halves the rate. Codes 1 and 2 alias to the slower rates of codes 8 and 9. A 3-bit divider-control field in register A can hold the divider in reset. While it is held, no flags are produced. When the hold is released, the tap phase starts again from zero.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset, register A reads 0x26 (divider field 010, rate code 0110), register B reads 0x00, register C reads 0x00 and `irq` is low.
- R2: Index 10 selects register A, index 11 selects register B and index 12 selects register C. Register A bit 7 always reads 0. Writes to register C have no effect.
- R3: With rate code 0 no periodic flag is ever set.
- R4: Rate code c in the range 3..15 sets the flag after every 2^(c-1) base ticks, counted from the divider restart.
- R5: Rate codes 1 and 2 give the same periods as codes 8 and 9, which are 128 and 256 base ticks.
- R6: The reset-default code 6 sets the flag every 32 base ticks (1024 Hz).
- R7: The periodic flag reads as bit 6 of register C. `irq` is high exactly when that flag and register B bit 6 are both set. Register C bit 7 mirrors `irq`.
- R8: A read of register C (`rd_en` with index 12) clears the flag at that clock edge. If a tap edge occurs in the same cycle, the flag stays set.
- R9: While register A bits 6:5 are both 1 (divider codes 110 and 111), the divider is held at zero and no flags are set. After release, the first flag comes a full period later.
- R10: Cycles without `base_tick` do not advance the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle strobe at the 32768 Hz base rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reading register C clears the flag) |
| addr | input | 4 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected index, combinational |
| irq | output | 1 | Periodic interrupt, active high |

## Verification
The hardest case to reach is a read of register C that lands in the same cycle as a tap edge. To reach it, the bench releases the divider at a known moment, counts base ticks to one short of the period, and then gives the final tick and the read together. A second hard case is a hold applied in the middle of a period. The bench stops partway through a period, holds the divider, releases it, and checks that the next flag needs a full period of ticks. Register C is also observed combinationally without `rd_en`, so the flag can be watched without clearing it.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int BASE_LOG2 = 15;
   localparam logic [6:0] REG_A_RST = 7'h26;
   localparam int FLAG_BIT = 6;
   localparam int EN_BIT = 6;
   typedef logic [3:0] rate_code_t;
endpackage

// File: rtl/pirq_rate_dec.sv
module pirq_rate_dec #(
   parameter int DIV_W = 15
) (
   input  logic [3:0]       code,
   output logic             active,
   output logic [DIV_W-1:0] mask
);
   logic [3:0] span;

   always_comb begin
      active = (code != 4'd0);
      unique case (code)
         4'd1:    span = 4'd7;
         4'd2:    span = 4'd8;
         default: span = code - 4'd1;
      endcase
   end

   for (genvar i = 0; i < DIV_W; i++) begin : g_mask
      if (i < 16) begin : g_in
         assign mask[i] = active && (4'(i) < span);
      end else begin : g_out
         assign mask[i] = 1'b0;
      end
   end
endmodule

// File: rtl/pirq_prescaler.sv
module pirq_prescaler #(
   parameter int DIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             base_tick,
   input  logic             active,
   input  logic [DIV_W-1:0] mask,
   output logic             tap_evt
);
   logic [DIV_W-1:0] cnt, cnt_nxt;

   assign cnt_nxt = cnt + 1'b1;
   assign tap_evt = run && base_tick && active && ((cnt_nxt & mask) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         cnt <= '0;
      else if (base_tick)
         cnt <= cnt_nxt;
   end
endmodule

// File: rtl/pirq_flag.sv
module pirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (set)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
   parameter int DIV_W  = 15,
   parameter int ADDR_W = 4,
   parameter int IDX_A  = 10,
   parameter int IDX_B  = 11,
   parameter int IDX_C  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq
);
   import pirq_pkg::*;

   if (DIV_W < BASE_LOG2) begin : g_chk_div
      $error("DIV_W too small for the slowest rate");
   end
   if (IDX_C >= (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W cannot reach all register indices");
   end

   localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(IDX_A);
   localparam logic [ADDR_W-1:0] SEL_B = ADDR_W'(IDX_B);
   localparam logic [ADDR_W-1:0] SEL_C = ADDR_W'(IDX_C);

   logic [6:0]       reg_a;
   logic [7:0]       reg_b;
   rate_code_t       rate_code;
   logic             div_run, rate_on, tap_evt, pi_flag, rd_clr_c;
   logic [DIV_W-1:0] tap_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_a <= REG_A_RST;
         reg_b <= 8'h00;
      end else if (wr_en) begin
         if (addr == SEL_A) reg_a <= wdata[6:0];
         if (addr == SEL_B) reg_b <= wdata;
      end
   end

   assign rate_code = reg_a[3:0];
   assign div_run   = (reg_a[6:5] != 2'b11);
   assign rd_clr_c  = rd_en && (addr == SEL_C);

   pirq_rate_dec #(.DIV_W(DIV_W)) u_dec (
      .code(rate_code), .active(rate_on), .mask(tap_mask)
   );

   pirq_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(div_run), .base_tick(base_tick),
      .active(rate_on), .mask(tap_mask), .tap_evt(tap_evt)
   );

   pirq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(tap_evt), .clr(rd_clr_c), .flag(pi_flag)
   );

   assign irq = pi_flag && reg_b[EN_BIT];

   always_comb begin
      if (addr == SEL_A)      rdata = {1'b0, reg_a};
      else if (addr == SEL_B) rdata = reg_b;
      else if (addr == SEL_C) rdata = {irq, pi_flag, 6'b0};
      else                    rdata = 8'h00;
   end
endmodule

// File: rtl/periodic_irq_chk.sv
module periodic_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       base_tick,
   input logic       div_run,
   input logic       tap_evt,
   input logic       pi_flag,
   input logic       rd_clr_c,
   input logic [3:0] rate_code
);
   // R9
   hold_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pi_flag) |-> $past(div_run));
   // R3
   code_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pi_flag) |-> $past(rate_code) != 4'd0);
   // R10
   tap_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_evt |-> base_tick);
   // R8
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_c && !tap_evt) |=> !pi_flag);
   // R8
   tap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_evt |=> pi_flag);
endmodule

bind periodic_irq_gen periodic_irq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .div_run(div_run),
   .tap_evt(tap_evt), .pi_flag(pi_flag), .rd_clr_c(rd_clr_c),
   .rate_code(rate_code)
);

// File: tb/test_periodic_irq_gen.sv
module test_periodic_irq_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [3:0] addr = 4'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   periodic_irq_gen i_periodic_irq_gen (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   // {rate code, expected period in base ticks}
   localparam logic [19:0] VECS [15] = '{
      {4'd1, 16'd128},  {4'd2, 16'd256},  {4'd3, 16'd4},    {4'd4, 16'd8},
      {4'd5, 16'd16},   {4'd6, 16'd32},   {4'd7, 16'd64},   {4'd8, 16'd128},
      {4'd9, 16'd256},  {4'd10, 16'd512}, {4'd11, 16'd1024},{4'd12, 16'd2048},
      {4'd13, 16'd4096},{4'd14, 16'd8192},{4'd15, 16'd16384}
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd_c();
      @(negedge clk); rd_en = 1'b1; addr = 4'd12;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk); base_tick = 1'b1;
      repeat (n) @(negedge clk);
      base_tick = 1'b0;
   endtask

   function automatic logic [7:0] peek_c();
      return {irq, 7'b0} | 8'h00;
   endfunction

   task automatic look(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; #1; v = rdata;
   endtask

   task automatic restart(input logic [3:0] code);
      wr(4'd10, {4'b0110, code});
      rd_c();
      wr(4'd10, {4'b0010, code});
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog got=hung exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      look(4'd10, v); check("R1 regA", v, 8'h26);
      look(4'd11, v); check("R1 regB", v, 8'h00);
      look(4'd12, v); check("R1 regC", v, 8'h00);
      check("R1 irq", {7'b0, irq}, 8'h00);

      // R4 R5 R6 table walk: period p -> quiet after p-1 ticks, flag at p
      for (int k = 0; k < 15; k++) begin
         restart(VECS[k][19:16]);
         ticks(int'(VECS[k][15:0]) - 1);
         look(4'd12, v); check($sformatf("R4/R5/R6 code%0d early", VECS[k][19:16]), v, 8'h00);
         ticks(1);
         look(4'd12, v); check($sformatf("R4/R5/R6 code%0d flag", VECS[k][19:16]), v, 8'h40);
      end

      // R8 read clears
      rd_c();
      look(4'd12, v); check("R8 cleared", v, 8'h00);

      // R3 code zero
      restart(4'd0);
      ticks(600);
      look(4'd12, v); check("R3 no flag", v, 8'h00);

      // R7 enable and irq
      wr(4'd11, 8'h40);
      look(4'd11, v); check("R2 regB", v, 8'h40);
      restart(4'd3);
      ticks(4);
      look(4'd12, v); check("R7 regC with en", v, 8'hC0);
      check("R7 irq high", {7'b0, irq}, 8'h01);
      rd_c();
      check("R7 irq low after read", {7'b0, irq}, 8'h00);
      wr(4'd11, 8'h00);
      ticks(4);
      look(4'd12, v); check("R7 flag without en", v, 8'h40);
      check("R7 irq masked", {7'b0, irq}, 8'h00);

      // R8 simultaneous tap and read: tap wins
      restart(4'd3);
      ticks(3);
      @(negedge clk); base_tick = 1'b1; rd_en = 1'b1; addr = 4'd12;
      @(negedge clk); base_tick = 1'b0; rd_en = 1'b0;
      look(4'd12, v); check("R8 tap wins", v, 8'h40);

      // R9 hold mid-period, phase restart
      restart(4'd3);
      ticks(2);
      wr(4'd10, 8'h63);
      ticks(10);
      look(4'd12, v); check("R9 held quiet", v, 8'h00);
      wr(4'd10, 8'h73);
      ticks(10);
      look(4'd12, v); check("R9 held 111 quiet", v, 8'h00);
      wr(4'd10, 8'h23);
      ticks(3);
      look(4'd12, v); check("R9 restart early", v, 8'h00);
      ticks(1);
      look(4'd12, v); check("R9 restart flag", v, 8'h40);

      // R2 write to C ignored, A bit7 reads 0
      rd_c();
      wr(4'd12, 8'hFF);
      look(4'd12, v); check("R2 C write ignored", v, 8'h00);
      wr(4'd10, 8'hA6);
      look(4'd10, v); check("R2 A bit7", v, 8'h26);

      // R10 no base tick, no progress
      restart(4'd3);
      ticks(3);
      repeat (50) @(negedge clk);
      look(4'd12, v); check("R10 idle no flag", v, 8'h00);
      ticks(1);
      look(4'd12, v); check("R10 resumes", v, 8'h40);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule